// File: doc/BRIEF.md
# Load/Store Effective Address and Data Alignment Unit

This block sits between an instruction's operand path and a single-word memory port. It takes a base register value and an offset that is either an immediate or already shifted, together with five control bits: add or subtract, index before or after, write the base back, byte or word size, and load or store. From these it forms the address presented to memory. It also lays out store data on the byte lanes of the bus, and it aligns the word that comes back. It reports the updated base address and whether that address must be written back to the register file.

Memory is modelled as answering in the same cycle as the request: read data and an error flag are sampled with the request. The load result, the writeback address and its enable, and a fault strobe are registered and appear on the following clock. Any access address at or above 2^LIMIT_BITS (2^26 by default) is refused: no bus request is made, and a fault is raised instead. A bus error raises the same fault. A fault suppresses both writeback and the load result.

Top module: `lsu_xfer_unit`

## Requirements
- R1: The updated address is base plus offset when `req_up` is 1 and base minus offset when it is 0, both modulo 2^32.
- R2: With `req_pre` = 1 the bus address is the updated address. With `req_pre` = 0 it is the unmodified base. `bus_req` is never high without `req_valid`.
- R3: One cycle after an access without fault, `wb_en` is 1 and `wb_addr` holds the updated address if `req_pre` = 0 or `req_wb` = 1. Otherwise `wb_en` is 0 and `wb_addr` is 0.
- R4: If the bus address is 2^26 or above, `bus_req` stays 0. On the next cycle `exc_strobe` is 1 and `wb_en` and `ld_en` are 0.
- R5: A `bus_err` sampled with an issued request gives the same result as R4 on the next cycle: `exc_strobe` is 1 and `wb_en` and `ld_en` are 0.
- R6: On a word load the read word is rotated right by 8 times bus address bits [1:0]. A value of 0 applies no rotation.
- R7: On a byte load the result is byte lane bus address [1:0] of the read word (lane k = bits 8k+7:8k), zero-extended to 32 bits.
- R8: A word store drives `req_sdata` unchanged on `bus_wdata` whatever the alignment. A byte store drives `req_sdata[7:0]` on all four byte lanes.
- R9: `bus_trans` is 1 only while a request is issued with `req_pre` = 0 and `req_wb` = 1.
- R10: The response outputs are registered. `rsp_valid` follows `req_valid` by one cycle. An idle cycle or reset leaves every response output at 0. `ld_data` is 0 unless `ld_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An access is requested this cycle |
| req_base | input | 32 | Base register value |
| req_offset | input | 32 | Immediate or shifted offset |
| req_up | input | 1 | 1 adds the offset, 0 subtracts it |
| req_pre | input | 1 | 1 indexes before the access, 0 after |
| req_wb | input | 1 | Write the base back on a pre-indexed access |
| req_byte | input | 1 | 1 byte access, 0 word access |
| req_load | input | 1 | 1 load, 0 store |
| req_sdata | input | 32 | Store data |
| bus_addr | output | 32 | Access address |
| bus_req | output | 1 | Memory access issued |
| bus_we | output | 1 | Access is a store |
| bus_byte | output | 1 | Access is byte sized |
| bus_wdata | output | 32 | Store data laid on byte lanes |
| bus_trans | output | 1 | Translate indication for post-indexed writeback accesses |
| bus_rdata | input | 32 | Raw read word from memory |
| bus_err | input | 1 | Memory reports an error for this access |
| rsp_valid | output | 1 | Response cycle for the previous request |
| exc_strobe | output | 1 | Address or bus fault on the previous request |
| wb_en | output | 1 | Write `wb_addr` to the base register |
| wb_addr | output | 32 | Updated base address |
| ld_en | output | 1 | `ld_data` holds a load result |
| ld_data | output | 32 | Aligned load result |

## Verification
The hardest case to reach is a request whose base and updated address fall on opposite sides of the 2^26 limit. Only the indexing mode then decides between a fault and a legal access followed by a writeback of an out-of-range base. The stimulus places bases just below the limit with small offsets in both directions and in both indexing modes. It also subtracts from a base of zero, so the updated address wraps modulo 2^32. Random bases drawn from a range twice the limit are mixed in.

// File: rtl/lsu_xfer_pkg.sv
package lsu_xfer_pkg;
   typedef struct packed {
      logic up;
      logic pre;
      logic wb;
      logic is_byte;
      logic load;
   } xfer_ctl_t;
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
   parameter int DATA_W     = 32,
   parameter int LIMIT_BITS = 26
) (
   input  logic [DATA_W-1:0] base,
   input  logic [DATA_W-1:0] offset,
   input  logic              up,
   input  logic              pre,
   output logic [DATA_W-1:0] acc_addr,
   output logic [DATA_W-1:0] next_addr,
   output logic              out_of_range
);
   assign next_addr = up ? (base + offset) : (base - offset);
   assign acc_addr  = pre ? next_addr : base;

   generate
      if (LIMIT_BITS >= DATA_W) begin : g_no_limit
         assign out_of_range = 1'b0;
      end else begin : g_limit
         assign out_of_range = |acc_addr[DATA_W-1:LIMIT_BITS];
      end
   endgenerate
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8
) (
   input  logic              is_byte,
   input  logic [DATA_W-1:0] sdata,
   output logic [DATA_W-1:0] wdata
);
   localparam int LANES = DATA_W / LANE_W;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign wdata[k*LANE_W +: LANE_W] = is_byte ? sdata[LANE_W-1:0]
                                                 : sdata[k*LANE_W +: LANE_W];
   end
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8,
   localparam int LANES = DATA_W / LANE_W,
   localparam int SEL_W = $clog2(LANES)
) (
   input  logic [DATA_W-1:0] rdata,
   input  logic [SEL_W-1:0]  lane_sel,
   input  logic              is_byte,
   output logic [DATA_W-1:0] ldata
);
   logic [LANE_W-1:0] in_lane [LANES];
   logic [DATA_W-1:0] rotated;

   for (genvar k = 0; k < LANES; k++) begin : g_rot
      logic [SEL_W-1:0] src;
      assign in_lane[k] = rdata[k*LANE_W +: LANE_W];
      assign src        = SEL_W'(k) + lane_sel;
      assign rotated[k*LANE_W +: LANE_W] = in_lane[src];
   end

   assign ldata = is_byte ? {{(DATA_W-LANE_W){1'b0}}, rotated[LANE_W-1:0]} : rotated;
endmodule

// File: rtl/lsu_xfer_unit.sv
module lsu_xfer_unit
   import lsu_xfer_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int LANE_W     = 8,
   parameter int LIMIT_BITS = 26
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [DATA_W-1:0] req_base,
   input  logic [DATA_W-1:0] req_offset,
   input  logic              req_up,
   input  logic              req_pre,
   input  logic              req_wb,
   input  logic              req_byte,
   input  logic              req_load,
   input  logic [DATA_W-1:0] req_sdata,
   output logic [DATA_W-1:0] bus_addr,
   output logic              bus_req,
   output logic              bus_we,
   output logic              bus_byte,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              bus_trans,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_err,
   output logic              rsp_valid,
   output logic              exc_strobe,
   output logic              wb_en,
   output logic [DATA_W-1:0] wb_addr,
   output logic              ld_en,
   output logic [DATA_W-1:0] ld_data
);
   localparam int LANES = DATA_W / LANE_W;
   localparam int SEL_W = $clog2(LANES);

   generate
      if (DATA_W % LANE_W != 0) begin : g_bad_lane
         $error("DATA_W must be a multiple of LANE_W");
      end
      if (LANES < 2 || (1 << SEL_W) != LANES) begin : g_bad_count
         $error("lane count must be a power of two, at least 2");
      end
      if (LIMIT_BITS < 1) begin : g_bad_limit
         $error("LIMIT_BITS must be positive");
      end
   endgenerate

   xfer_ctl_t         ctl;
   logic [DATA_W-1:0] acc_addr, next_addr, aligned;
   logic              oor, access_ok, wb_want;

   assign ctl = '{up: req_up, pre: req_pre, wb: req_wb, is_byte: req_byte, load: req_load};

   lsu_addr_gen #(.DATA_W(DATA_W), .LIMIT_BITS(LIMIT_BITS)) u_addr (
      .base(req_base), .offset(req_offset), .up(ctl.up), .pre(ctl.pre),
      .acc_addr(acc_addr), .next_addr(next_addr), .out_of_range(oor)
   );

   lsu_store_lanes #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_store (
      .is_byte(ctl.is_byte), .sdata(req_sdata), .wdata(bus_wdata)
   );

   lsu_load_align #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_load (
      .rdata(bus_rdata), .lane_sel(acc_addr[SEL_W-1:0]), .is_byte(ctl.is_byte),
      .ldata(aligned)
   );

   assign bus_addr  = acc_addr;
   assign bus_req   = req_valid & ~oor;
   assign bus_we    = ~ctl.load;
   assign bus_byte  = ctl.is_byte;
   assign bus_trans = bus_req & ~ctl.pre & ctl.wb;
   assign access_ok = bus_req & ~bus_err;
   assign wb_want   = ~ctl.pre | ctl.wb;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         exc_strobe <= 1'b0;
         wb_en      <= 1'b0;
         wb_addr    <= '0;
         ld_en      <= 1'b0;
         ld_data    <= '0;
      end else begin
         rsp_valid  <= req_valid;
         exc_strobe <= req_valid & ~access_ok;
         wb_en      <= access_ok & wb_want;
         wb_addr    <= (access_ok & wb_want) ? next_addr : '0;
         ld_en      <= access_ok & ctl.load;
         ld_data    <= (access_ok & ctl.load) ? aligned : '0;
      end
   end
endmodule

// File: rtl/lsu_xfer_unit_chk.sv
module lsu_xfer_unit_chk #(
   parameter int DATA_W     = 32,
   parameter int LANE_W     = 8,
   parameter int LIMIT_BITS = 26
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_pre,
   input logic              req_wb,
   input logic [DATA_W-1:0] req_sdata,
   input logic [DATA_W-1:0] bus_addr,
   input logic              bus_req,
   input logic              bus_we,
   input logic              bus_byte,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_trans,
   input logic              rsp_valid,
   input logic              exc_strobe,
   input logic              wb_en,
   input logic              ld_en
);
   assert_idle_no_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> !bus_req);

   assert_range_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> ((bus_addr >> LIMIT_BITS) == '0));

   assert_refused_faults_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !bus_req) |=> exc_strobe);

   assert_fault_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      exc_strobe |-> (!wb_en && !ld_en));

   assert_word_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && !bus_byte) |-> (bus_wdata == req_sdata));

   assert_byte_repl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && bus_byte) |->
         (bus_wdata[DATA_W-1 -: LANE_W] == bus_wdata[LANE_W-1:0]));

   assert_trans_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_trans |-> (bus_req && !req_pre && req_wb));

   assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !exc_strobe && !wb_en && !ld_en));
endmodule

bind lsu_xfer_unit lsu_xfer_unit_chk #(
   .DATA_W(DATA_W), .LANE_W(LANE_W), .LIMIT_BITS(LIMIT_BITS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pre(req_pre),
   .req_wb(req_wb), .req_sdata(req_sdata), .bus_addr(bus_addr),
   .bus_req(bus_req), .bus_we(bus_we), .bus_byte(bus_byte),
   .bus_wdata(bus_wdata), .bus_trans(bus_trans), .rsp_valid(rsp_valid),
   .exc_strobe(exc_strobe), .wb_en(wb_en), .ld_en(ld_en)
);

// File: tb/lsu_xfer_unit_bench.sv
`timescale 1ns/1ps
module lsu_xfer_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_base = '0, req_offset = '0, req_sdata = '0, bus_rdata = '0;
   logic        req_up = 1'b0, req_pre = 1'b0, req_wb = 1'b0;
   logic        req_byte = 1'b0, req_load = 1'b0, bus_err = 1'b0;
   logic [31:0] bus_addr, bus_wdata, wb_addr, ld_data;
   logic        bus_req, bus_we, bus_byte, bus_trans;
   logic        rsp_valid, exc_strobe, wb_en, ld_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] e_wb_addr = '0, e_ld_data = '0;
   logic        e_rsp = 1'b0, e_exc = 1'b0, e_wb = 1'b0, e_ld = 1'b0;

   always #2.5 clk = ~clk;

   lsu_xfer_unit u_lsu_xfer_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_base(req_base),
      .req_offset(req_offset), .req_up(req_up), .req_pre(req_pre),
      .req_wb(req_wb), .req_byte(req_byte), .req_load(req_load),
      .req_sdata(req_sdata), .bus_addr(bus_addr), .bus_req(bus_req),
      .bus_we(bus_we), .bus_byte(bus_byte), .bus_wdata(bus_wdata),
      .bus_trans(bus_trans), .bus_rdata(bus_rdata), .bus_err(bus_err),
      .rsp_valid(rsp_valid), .exc_strobe(exc_strobe), .wb_en(wb_en),
      .wb_addr(wb_addr), .ld_en(ld_en), .ld_data(ld_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_rsp();
      chk("R10 rsp_valid", 32'(rsp_valid), 32'(e_rsp));
      chk("R4/R5 exc_strobe", 32'(exc_strobe), 32'(e_exc));
      chk("R3 wb_en", 32'(wb_en), 32'(e_wb));
      chk("R1/R3 wb_addr", wb_addr, e_wb_addr);
      chk("R4/R5 ld_en", 32'(ld_en), 32'(e_ld));
      chk("R6/R7 ld_data", ld_data, e_ld_data);
   endtask

   // One clock: check previous response, drive a request, check bus side, predict.
   task automatic step(input bit v, input bit up, input bit pre, input bit wb,
                       input bit byt, input bit ld, input logic [31:0] base,
                       input logic [31:0] off, input logic [31:0] sd,
                       input logic [31:0] rd, input bit err);
      longint nxt, acc, rot, sh;
      bit oor, ok, wbw;
      logic [31:0] wexp, lval;
      @(negedge clk);
      check_rsp();
      req_valid = v; req_up = up; req_pre = pre; req_wb = wb; req_byte = byt;
      req_load = ld; req_base = base; req_offset = off; req_sdata = sd;
      bus_rdata = rd; bus_err = err;
      #1;
      nxt  = up ? ((longint'(base) + longint'(off)) & 64'hFFFF_FFFF)
                : ((longint'(base) - longint'(off)) & 64'hFFFF_FFFF);
      acc  = pre ? nxt : longint'(base);
      oor  = (acc >= 64'h400_0000);
      ok   = v && !oor && !err;
      wbw  = !pre || wb;
      sh   = acc % 4;
      rot  = ((longint'(rd) >> (8*sh)) | (longint'(rd) << (32 - 8*sh))) & 64'hFFFF_FFFF;
      lval = byt ? 32'(rot & 64'hFF) : 32'(rot);
      wexp = byt ? {4{sd[7:0]}} : sd;
      chk("R2 bus_addr", bus_addr, 32'(acc));
      chk("R2/R4 bus_req", 32'(bus_req), 32'(v && !oor));
      chk("R9 bus_trans", 32'(bus_trans), 32'(v && !oor && !pre && wb));
      if (v && !ld) chk("R8 bus_wdata", bus_wdata, wexp);
      e_rsp     = v;
      e_exc     = v && !ok;
      e_wb      = ok && wbw;
      e_wb_addr = (ok && wbw) ? 32'(nxt) : 32'h0;
      e_ld      = ok && ld;
      e_ld_data = (ok && ld) ? lval : 32'h0;
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 32'h0, 32'h0, 32'h0, 32'h0, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // Reset state: R10
      idle();
      // All flag combinations at every alignment: R1 R2 R3 R6 R7 R8 R9
      for (int f = 0; f < 32; f++) begin
         for (int a = 0; a < 4; a++) begin
            step(1, f[0], f[1], f[2], f[3], f[4], 32'h0001_2340 + 32'(a),
                 32'h0000_0024 + 32'(f), 32'hC3A5_5A7E ^ 32'(f << 8),
                 32'h8877_6655 + 32'(a * 32'h0101_0101), 0);
         end
      end
      idle();
      // Limit boundary: R4
      step(1, 1, 1, 0, 0, 1, 32'h03FF_FFFC, 32'h4, 32'h0, 32'hDEAD_BEEF, 0);
      step(1, 1, 0, 0, 0, 1, 32'h03FF_FFFC, 32'h4, 32'h0, 32'hDEAD_BEEF, 0);
      step(1, 1, 1, 1, 0, 1, 32'h03FF_FFFB, 32'h4, 32'h0, 32'h1234_5678, 0);
      step(1, 0, 1, 1, 1, 0, 32'h0, 32'h4, 32'h0000_00A7, 32'h0, 0);
      step(1, 0, 0, 1, 0, 0, 32'h0, 32'h4, 32'h5566_7788, 32'h0, 0);
      step(1, 1, 0, 0, 0, 0, 32'h0400_0000, 32'h0, 32'h1, 32'h0, 0);
      // Bus error: R5
      step(1, 1, 1, 1, 0, 1, 32'h100, 32'h3, 32'h0, 32'hAABB_CCDD, 1);
      step(1, 1, 0, 0, 1, 0, 32'h200, 32'h8, 32'h33, 32'h0, 1);
      idle();
      idle();
      // Mixed random traffic with idle gaps
      for (int i = 0; i < 400; i++) begin
         logic [31:0] r;
         r = $urandom;
         step(r[0] | r[1], r[2], r[3], r[4], r[5], r[6], $urandom & 32'h07FF_FFFF,
              $urandom & 32'h0000_0FFF, $urandom, $urandom, (r[9:7] == 3'b000));
      end
      idle();
      @(negedge clk);
      check_rsp();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule